// File: doc/BRIEF.md
# Folding Converter Coarse/Fine Code Assembler

This block is the digital back end of a 9-bit folding analog-to-digital converter. The converter splits its range into 63-step folds. Each cycle the block receives two comparator vectors. The first is a 9-wide coarse vector, a plain thermometer code that counts how many fold boundaries the input has crossed. The second is a 63-wide fine vector, a cyclic thermometer that gives the position inside the current fold. The block turns both into binary and joins them into one 9-bit sample code.

Because a fold spans 63 steps rather than 64, the fine position cannot simply be concatenated with the coarse count. A first small table maps the coarse count k to the offset 64 - k. An adder sums that offset with the fine position. The adder's top bit then chooses between two coarse tables: one gives k - 1 and the other gives k. The chosen coarse value and the lower six sum bits form the code 63k + r.

The two comparator banks are sampled at slightly different instants, so the coarse count can be one fold off near a fold edge. A correction stage detects this from the disagreement between the parity of the coarse count and the phase of the fine vector. In that case it swaps in an alternate code that was prepared one cycle earlier. Single-bit bubbles in either vector are removed before decoding. Each result is registered and travels with a valid flag.

Top module: `fold_enc`

## Requirements
- R1: While synchronous reset is high, `code` is 0 and `code_valid` is 0 on the following cycle, whatever the inputs are.
- R2: A sample presented with `in_valid` high on one rising edge appears on `code`, with `code_valid` high, after the second rising edge that follows. A sample with `in_valid` low yields `code_valid` low at that same point.
- R3: For a clean input at level L (0 to 511), the block reports `code` = L. Here coarse bit j is 1 exactly when j < L/63 (integer division), and the fine vector follows R4 with r = L mod 63.
- R4: The fine vector is cyclic. Fine bit 62 gives the fold phase. With bit 62 low (even fold), the fold position r equals the number of ones, and the ones sit at bits 0 to r-1. With bit 62 high (odd fold), bits 0 to r-1 are zero and the rest are one, so r equals 63 minus the number of ones.
- R5: The coarse count k and the position r combine as 63k + r. When r < k, the result must borrow correctly from the coarse field (for example k=5, r=2 gives 317).
- R6: If the coarse count is one lower than the fold given by the fine phase and r < 32, the block reports the code of the next fold up.
- R7: If the coarse count is one higher than the fold given by the fine phase and r >= 32, the block reports the code of the next fold down.
- R8: A single isolated flipped bit inside a run of equal bits, in either vector, does not change the code. Each bit is replaced by the majority of itself and its two neighbours. Coarse bit -1 counts as 1 and coarse bit 9 counts as 0. Fine bit -1 counts as the inverse of fine bit 62, and fine bit 63 counts as the inverse of fine bit 0.
- R9: The code saturates. All-zero vectors give 0. An all-ones coarse vector gives 511. A value above 511 (coarse count 8 with r >= 8) gives 511. A downward correction below fold 0 gives 0.
- R10: A sweep of the input level from 0 to 511 produces output codes that never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the comparator vectors as a sample |
| coarse_cmp | input | 9 | Coarse comparator thermometer vector |
| fine_cmp | input | 63 | Fine comparator cyclic thermometer vector |
| code | output | 9 | Assembled sample code |
| code_valid | output | 1 | Valid flag that travels with `code` |

## Verification
The bench builds the block only with its default parameters: nine coarse comparators and sixty-three fine comparators. These are the only values for which 63-step folds pack exactly into a 9-bit code, so every fold edge and every borrow case of the adder can be reached. A full level sweep covers all 512 codes, including the top fold, where r < k on every step. Separate vectors shift the coarse count by one fold on either side of a fold edge, inject single-bit bubbles, and drive the saturation patterns.

// File: rtl/fold_enc.sv
module fold_enc #(
  parameter int CW = 9,
  parameter int FW = 63,
  localparam int FB = $clog2(FW + 1),
  localparam int OW = FB + $clog2(CW - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] coarse_cmp,
  input  logic [FW-1:0] fine_cmp,
  output logic [OW-1:0] code,
  output logic          code_valid
);
  localparam int KB = $clog2(CW + 2);
  localparam int CB = OW - FB;

  logic [CW+1:0] c_ext;
  logic [FW+1:0] f_ext;
  logic [CW-1:0] c_cl;
  logic [FW-1:0] f_cl;

  assign c_ext = {1'b0, coarse_cmp, 1'b1};
  assign f_ext = {~fine_cmp[0], fine_cmp, ~fine_cmp[FW-1]};

  for (genvar i = 0; i < CW; i++) begin : g_cmaj
    assign c_cl[i] = (c_ext[i] & c_ext[i+1]) | (c_ext[i] & c_ext[i+2]) | (c_ext[i+1] & c_ext[i+2]);
  end
  for (genvar i = 0; i < FW; i++) begin : g_fmaj
    assign f_cl[i] = (f_ext[i] & f_ext[i+1]) | (f_ext[i] & f_ext[i+2]) | (f_ext[i+1] & f_ext[i+2]);
  end

  function automatic logic [KB-1:0] c_rom(input logic [CW-1:0] v);
    logic [KB-1:0] n;
    n = '0;
    for (int i = 0; i < CW; i++) n = n + KB'(v[i]);
    return n;
  endfunction

  function automatic logic [FB-1:0] f_rom(input logic [FW-1:0] v);
    logic [FB-1:0] n;
    n = '0;
    for (int i = 0; i < FW; i++) n = n + FB'(v[i]);
    return n;
  endfunction

  function automatic logic [OW-1:0] join_code(input logic [KB-1:0] k, input logic [FB-1:0] r, input logic under);
    logic [FB:0]   ofs, sum;
    logic [KB-1:0] lo_sel, hi_sel, crs;
    ofs    = (FB+1)'(FW + 1) - (FB+1)'(k);
    sum    = {1'b0, r} + ofs;
    lo_sel = k - KB'(1);
    hi_sel = k;
    crs    = sum[FB] ? hi_sel : lo_sel;
    if (under) return '0;
    if (crs >= KB'(1 << CB)) return '1;
    return {crs[CB-1:0], sum[FB-1:0]};
  endfunction

  logic [KB-1:0] k_now, k_alt;
  logic [FB-1:0] f_ones, r_pos;
  logic          f_phase, go_down, mismatch, under;

  assign k_now    = c_rom(c_cl);
  assign f_ones   = f_rom(f_cl);
  assign f_phase  = f_cl[FW-1];
  assign r_pos    = f_phase ? FB'(FW) - f_ones : f_ones;
  assign mismatch = k_now[0] ^ f_phase;
  assign go_down  = r_pos[FB-1];
  assign under    = go_down && (k_now == '0);
  assign k_alt    = go_down ? k_now - KB'(1) : k_now + KB'(1);

  logic [OW-1:0] s1_main, s1_alt;
  logic          s1_fix, s1_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_main <= '0;
      s1_alt  <= '0;
      s1_fix  <= 1'b0;
      s1_v    <= 1'b0;
      code       <= '0;
      code_valid <= 1'b0;
    end else begin
      s1_main <= join_code(k_now, r_pos, 1'b0);
      s1_alt  <= join_code(k_alt, r_pos, under);
      s1_fix  <= mismatch;
      s1_v    <= in_valid;
      code       <= s1_fix ? s1_alt : s1_main;
      code_valid <= s1_v;
    end
  end
endmodule

module fold_enc_chk #(
  parameter int CW = 9,
  parameter int FW = 63,
  parameter int OW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [CW-1:0] coarse_cmp,
  input logic [FW-1:0] fine_cmp,
  input logic [OW-1:0] code,
  input logic          code_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (code == '0 && !code_valid));
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> ##1 code_valid);
  // R2
  idle_lat_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ##1 !code_valid);
  // R9
  sat_top_chk: assert property (@(posedge clk) disable iff (rst) (in_valid && (&coarse_cmp)) |=> ##1 (code == '1));
  // R9
  sat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coarse_cmp == '0 && fine_cmp == '0) |=> ##1 (code == '0));
endmodule

bind fold_enc fold_enc_chk #(.CW(CW), .FW(FW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .coarse_cmp(coarse_cmp),
  .fine_cmp(fine_cmp), .code(code), .code_valid(code_valid)
);

// File: tb/tb_fold_enc.sv
`timescale 1ns/1ps
module tb_fold_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vin = 1'b0;
  logic [8:0]  coarse = '0;
  logic [62:0] fine = '0;
  logic [8:0]  code;
  logic        code_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int last_mono = -1;

  int    q_exp[$];
  bit    q_v[$];
  string q_tag[$];
  bit    q_mono[$];

  always #2 clk = ~clk;

  fold_enc dut (
    .clk(clk), .rst(rst), .in_valid(vin), .coarse_cmp(coarse),
    .fine_cmp(fine), .code(code), .code_valid(code_valid)
  );

  function automatic void gen(input int lvl, input int dc, output logic [8:0] cv, output logic [62:0] fv);
    int fold = lvl / 63;
    int r = lvl % 63;
    int c = fold + dc;
    cv = '0;
    for (int j = 0; j < 9; j++) cv[j] = (j < c);
    for (int j = 0; j < 63; j++) fv[j] = (fold % 2 == 0) ? (j < r) : (j >= r);
  endfunction

  task automatic compare();
    int    ex = q_exp.pop_front();
    bit    v  = q_v.pop_front();
    string tg = q_tag.pop_front();
    bit    mo = q_mono.pop_front();
    checks++;
    if (code_valid !== v) begin
      errors++;
      $display("FAIL %s valid: actual %0b expected %0b", tg, code_valid, v);
    end
    if (v) begin
      checks++;
      if (code !== ex[8:0]) begin
        errors++;
        $display("FAIL %s code: actual %0d expected %0d", tg, code, ex);
      end
      if (mo) begin
        checks++;
        if (int'(code) < last_mono) begin
          errors++;
          $display("FAIL R10 monotonic: actual %0d expected >= %0d", code, last_mono);
        end
        last_mono = int'(code);
      end
    end
  endtask

  task automatic step(input logic [8:0] cv, input logic [62:0] fv, input bit v, input int ex, input string tg, input bit mo);
    @(negedge clk);
    if (q_exp.size() > 0) compare();
    rst = 1'b0;
    coarse = cv; fine = fv; vin = v;
    q_exp.push_back(ex); q_v.push_back(v); q_tag.push_back(tg); q_mono.push_back(mo);
  endtask

  task automatic lvl_step(input int lvl, input int dc, input string tg, input bit mo);
    logic [8:0]  cv;
    logic [62:0] fv;
    gen(lvl, dc, cv, fv);
    step(cv, fv, 1'b1, lvl, tg, mo);
  endtask

  initial begin
    logic [8:0]  cv;
    logic [62:0] fv;
    vin = 1'b1; coarse = 9'h1FF; fine = '1;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (code !== 9'd0 || code_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: actual %0d/%0b expected 0/0", code, code_valid);
      end
    end
    for (int i = 0; i < 2; i++) begin
      q_exp.push_back(0); q_v.push_back(1'b0); q_tag.push_back("R1"); q_mono.push_back(1'b0);
    end

    for (int l = 0; l < 512; l++) lvl_step(l, 0, "R3", 1'b1);

    // R4 odd folds and R5 borrow cases
    lvl_step(63 * 3 + 10, 0, "R4", 1'b0);
    lvl_step(63 * 7 + 62, 0, "R4", 1'b0);
    lvl_step(63 * 5 + 2, 0, "R5", 1'b0);
    lvl_step(63 * 8 + 7, 0, "R5", 1'b0);
    lvl_step(63 * 6 + 0, 0, "R5", 1'b0);

    // R6 coarse late, R7 coarse early
    for (int f = 1; f <= 8; f++) for (int r = 0; r < 3; r++) lvl_step(63 * f + r, -1, "R6", 1'b0);
    for (int f = 0; f <= 7; f++) for (int r = 60; r < 63; r++) lvl_step(63 * f + r, 1, "R7", 1'b0);

    // R8 bubbles
    gen(63 * 2 + 40, 0, cv, fv); fv[10] = 1'b0; step(cv, fv, 1'b1, 166, "R8", 1'b0);
    gen(63 * 2 + 40, 0, cv, fv); fv[50] = 1'b1; step(cv, fv, 1'b1, 166, "R8", 1'b0);
    gen(63 * 2 + 40, 0, cv, fv); cv[5] = 1'b1;  step(cv, fv, 1'b1, 166, "R8", 1'b0);
    gen(63 * 3 + 20, 0, cv, fv); fv[45] = 1'b0; step(cv, fv, 1'b1, 209, "R8", 1'b0);

    // R9 saturation
    step('0, '0, 1'b1, 0, "R9", 1'b0);
    step('1, '1, 1'b1, 511, "R9", 1'b0);
    gen(63 * 8, 0, cv, fv); for (int j = 0; j < 63; j++) fv[j] = (j < 20);
    step(cv, fv, 1'b1, 511, "R9", 1'b0);
    for (int j = 0; j < 63; j++) fv[j] = (j >= 40);
    step('0, fv, 1'b1, 0, "R9", 1'b0);

    // R2 gaps in valid
    lvl_step(100, 0, "R2", 1'b0);
    step('0, '0, 1'b0, 0, "R2", 1'b0);
    lvl_step(300, 0, "R2", 1'b0);
    step('0, '0, 1'b0, 0, "R2", 1'b0);
    step('0, '0, 1'b0, 0, "R2", 1'b0);
    step('0, '0, 1'b0, 0, "R2", 1'b0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule